// File: doc/BRIEF.md
# Link Event Interrupt Controller

This block gathers seven link-management events from a 10/100 transceiver into a sticky source register. It qualifies them with a mask register and drives one active-low interrupt line towards the host. Software reaches the source register, the mask register and a small mode register through a single-cycle register port. The register port returns read data in the same cycle as the read strobe. A read of the source register clears the bits it returns.

The block also keeps the energy-present status. This flag is set at hard reset. It drops after a parameterised number of clock cycles in which no valid line energy is seen, and it returns as soon as energy reappears. Each return of energy latches the highest source bit. Software can clear that bit by reading the source register. It can also clear it by writing 1 to mask bit 7 once energy has gone again, which the other sources do not allow.

A software reset input returns the programmable state to its defaults. It leaves the energy status untouched. The interrupt line is registered, so it never glitches while the source and mask registers change.

Top module: `link_irq_ctrl`

## Requirements
- R1: Register address 0 is the source register. A high level on an event input in a cycle sets its bit at the next clock edge. The bit mapping is: page received = bit 1, parallel-detection fault = bit 2, partner acknowledge = bit 3, link down = bit 4, remote fault = bit 5, negotiation done = bit 6, energy return = bit 7. Bit 0 and bits 15:8 always read 0.
- R2: A source bit stays set until the source register is read. That read returns the bit and clears it at the same edge, unless the bit's event is active in the read cycle, in which case the bit stays set.
- R3: The interrupt line goes low on the second clock edge after a source bit latches, and only if that bit's mask bit is set. It never goes low while all mask bits are zero.
- R4: Clearing the mask bits drives the interrupt line high on the second edge after the write. Clearing the pending source bits by a read does the same.
- R5: The energy status reads 1 after hard reset. It falls to 0 at the clock edge that completes NOENERGY_CYCLES consecutive cycles without energy. It returns to 1 at the first edge with energy, and that return sets source bit 7. A fall of the status sets no source bit.
- R6: A write to address 1 with data bit 7 = 1 clears source bit 7 while the energy status is 0. The same write leaves source bit 7 set while the status is 1.
- R7: Address 1 is the mask register: bits 7:1 are writable. Bit 0 and bits 15:8 read 0 and ignore writes. Writes to address 0 and address 3 have no effect. Address 3 reads 0.
- R8: Address 2 is the mode register. Bit 0 is the alternate-mode select: it can be read and written, and it is 0 after hard reset. Bit 1 returns the energy status and cannot be written. All other bits read 0. After hard reset the source and mask registers are 0 and the interrupt line is high.
- R9: A software reset pulse clears the source register, the mask register and the alternate-mode bit. It does not change the energy status or its timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low hard reset, asynchronous |
| soft_rst_i | input | 1 | Synchronous software reset |
| energy_i | input | 1 | Valid line energy seen this cycle |
| an_done_i | input | 1 | Negotiation complete event |
| rem_fault_i | input | 1 | Remote fault event |
| link_down_i | input | 1 | Link lost event |
| lp_ack_i | input | 1 | Link-partner acknowledge event |
| pd_fault_i | input | 1 | Parallel-detection fault event |
| page_rx_i | input | 1 | Page received event |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe (source read clears) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid in the strobe cycle |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
Each result has a fixed due time:
- Read data is due in the cycle of the read strobe. The bench samples it at the falling edge inside that cycle, against an expectation queued when the read was driven.
- A latched source bit or a written mask reaches the interrupt line two rising edges after its stimulus. The bench therefore checks the line once after the first edge, expecting no change, and again after the second edge.
- The energy timeout is checked one cycle before and at the edge that completes the window. This shows the status falls exactly at NOENERGY_CYCLES and not earlier.

// File: rtl/link_irq_pkg.sv
package link_irq_pkg;

    localparam int unsigned REG_W    = 16;
    localparam int unsigned N_EVENTS = 7;
    localparam int unsigned SRC_W    = N_EVENTS + 1;
    localparam int unsigned ENERGY_BIT = SRC_W - 1;

    typedef enum logic [1:0] {
        ADDR_SRC  = 2'd0,
        ADDR_MASK = 2'd1,
        ADDR_MODE = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [SRC_W-1:0] mask;
        logic             alt;
    } irq_regs_t;

endpackage

// File: rtl/link_energy_mon.sv
module link_energy_mon #(
    parameter int unsigned CYCLES = 32_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic energy_i,
    output logic on_o,
    output logic rise_o
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          on;
        logic [CW-1:0] cnt;
    } emon_t;

    emon_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (energy_i) begin
            st_d.on  = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.on) begin
            if (st_q.cnt == LAST) begin
                st_d.on  = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.on  <= 1'b1;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign on_o   = st_q.on;
    assign rise_o = energy_i & ~st_q.on;

    p_energy_return_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        energy_i |=> on_o)
        else $error("energy status did not return");

    p_energy_fall_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(on_o) |-> $past(!energy_i))
        else $error("energy status fell while energy present");

endmodule

// File: rtl/link_irq_regs.sv
module link_irq_regs
    import link_irq_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             soft_rst_i,
    input  logic [SRC_W-1:0] set_i,
    input  logic             energy_on_i,
    input  logic [1:0]       addr_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [SRC_W-1:0] src_o,
    output logic [SRC_W-1:0] mask_o,
    output logic [REG_W-1:0] rdata_o
);
    localparam logic [SRC_W-1:0] VALID = {{N_EVENTS{1'b1}}, 1'b0};

    irq_regs_t r_d, r_q;
    reg_addr_e addr;
    logic      rd_src, wr_mask, wr_mode;
    logic      unused_wdata_hi;

    assign addr            = reg_addr_e'(addr_i);
    assign rd_src          = rd_i && (addr == ADDR_SRC);
    assign wr_mask         = wr_i && (addr == ADDR_MASK);
    assign wr_mode         = wr_i && (addr == ADDR_MODE);
    assign unused_wdata_hi = ^wdata_i[REG_W-1:SRC_W];

    always_comb begin
        r_d = r_q;
        if (rd_src) begin
            r_d.src = '0;
        end
        if (wr_mask && wdata_i[ENERGY_BIT] && !energy_on_i) begin
            r_d.src[ENERGY_BIT] = 1'b0;
        end
        r_d.src = r_d.src | (set_i & VALID);
        if (wr_mask) begin
            r_d.mask = wdata_i[SRC_W-1:0] & VALID;
        end
        if (wr_mode) begin
            r_d.alt = wdata_i[0];
        end
        if (soft_rst_i) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr)
            ADDR_SRC:  rdata_o[SRC_W-1:0] = r_q.src;
            ADDR_MASK: rdata_o[SRC_W-1:0] = r_q.mask;
            ADDR_MODE: rdata_o[1:0]       = {energy_on_i, r_q.alt};
            default:   rdata_o            = '0;
        endcase
    end

    assign src_o  = r_q.src;
    assign mask_o = r_q.mask;

    for (genvar k = 1; k < SRC_W; k++) begin : g_latch_chk
        p_event_latches_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (set_i[k] && !soft_rst_i) |=> src_o[k])
            else $error("source bit %0d failed to latch", k);
    end

    p_read_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_src && (set_i & VALID) == '0) |=> (src_o == '0))
        else $error("source read did not clear");

    p_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o[REG_W-1:SRC_W] == '0)
        else $error("upper read bits not zero");

    p_soft_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (src_o == '0 && mask_o == '0))
        else $error("software reset left state");

endmodule

// File: rtl/link_irq_ctrl.sv
module link_irq_ctrl
    import link_irq_pkg::*;
#(
    parameter int unsigned NOENERGY_CYCLES = 32_000_000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        soft_rst_i,
    input  logic        energy_i,
    input  logic        an_done_i,
    input  logic        rem_fault_i,
    input  logic        link_down_i,
    input  logic        lp_ack_i,
    input  logic        pd_fault_i,
    input  logic        page_rx_i,
    input  logic [1:0]  reg_addr_i,
    input  logic        reg_wr_i,
    input  logic        reg_rd_i,
    input  logic [15:0] reg_wdata_i,
    output logic [15:0] reg_rdata_o,
    output logic        irq_n_o
);
    logic             energy_on, energy_rise;
    logic [SRC_W-1:0] set_vec, src, mask;
    logic             irq_n_d, irq_n_q;

    link_energy_mon #(.CYCLES(NOENERGY_CYCLES)) u_energy (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .energy_i (energy_i),
        .on_o     (energy_on),
        .rise_o   (energy_rise)
    );

    assign set_vec = {energy_rise, an_done_i, rem_fault_i, link_down_i,
                      lp_ack_i, pd_fault_i, page_rx_i, 1'b0};

    link_irq_regs u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .soft_rst_i  (soft_rst_i),
        .set_i       (set_vec),
        .energy_on_i (energy_on),
        .addr_i      (reg_addr_i),
        .wr_i        (reg_wr_i),
        .rd_i        (reg_rd_i),
        .wdata_i     (reg_wdata_i),
        .src_o       (src),
        .mask_o      (mask),
        .rdata_o     (reg_rdata_o)
    );

    always_comb begin
        irq_n_d = ~|(src & mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_n_q <= 1'b1;
        end else begin
            irq_n_q <= irq_n_d;
        end
    end

    assign irq_n_o = irq_n_q;

    p_irq_needs_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_n_o |-> $past(mask != '0))
        else $error("interrupt without any mask bit");

    p_mask_clear_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == 2'd1 && reg_wdata_i[SRC_W-1:1] == '0)
            |=> ##1 irq_n_o)
        else $error("interrupt held after mask cleared");

endmodule

// File: tb/link_irq_ctrl_test.sv
module link_irq_ctrl_test;

    localparam int unsigned NOE = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        energy = 1'b1;
    logic [6:1]  ev = '0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    link_irq_ctrl #(.NOENERGY_CYCLES(NOE)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .soft_rst_i  (soft_rst),
        .energy_i    (energy),
        .an_done_i   (ev[6]),
        .rem_fault_i (ev[5]),
        .link_down_i (ev[4]),
        .lp_ack_i    (ev[3]),
        .pd_fault_i  (ev[2]),
        .page_rx_i   (ev[1]),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_n_o     (irq_n)
    );

    // monitor: read data due in the strobe cycle, sampled mid-cycle
    always @(negedge clk) begin
        if (rd) begin
            exp_t e;
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read with no expectation, got %h", rdata);
            end else begin
                e = sb.pop_front();
                if (rdata !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d read %h expected %h", e.tag, addr, rdata, e.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic reg_read(input logic [1:0] a, input logic [15:0] exp, input string tag);
        exp_t e;
        e.exp = exp;
        e.tag = tag;
        sb.push_back(e);
        addr = a;
        rd = 1'b1;
        tick();
        rd = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        addr = a;
        wdata = d;
        wr = 1'b1;
        tick();
        wr = 1'b0;
    endtask

    task automatic pulse(input int k);
        ev[k] = 1'b1;
        tick();
        ev = '0;
    endtask

    task automatic check_irq(input logic exp, input string tag);
        n_tests++;
        if (irq_n !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_n %b expected %b", tag, irq_n, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            if (sb.size() != 0) begin
                n_fail++;
                $display("FAIL scoreboard: %0d reads outstanding", sb.size());
            end
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        tick();

        // R8 reset state, R5 energy status set after reset
        check_irq(1'b1, "R8");
        reg_read(2'd0, 16'h0000, "R8");
        reg_read(2'd1, 16'h0000, "R8");
        reg_read(2'd2, 16'h0002, "R5");

        // R1 each event latches its own bit; R3 no interrupt with mask zero
        for (int k = 1; k <= 6; k++) begin
            pulse(k);
            reg_read(2'd0, 16'(1 << k), "R1");
        end
        ev = 6'h3F;
        tick();
        ev = '0;
        reg_read(2'd0, 16'h007E, "R1");
        reg_read(2'd0, 16'h0000, "R2");
        check_irq(1'b1, "R3");

        // R2 active event survives the clearing read
        ev[3] = 1'b1;
        tick();
        reg_read(2'd0, 16'h0008, "R2");
        reg_read(2'd0, 16'h0008, "R2");
        ev = '0;
        reg_read(2'd0, 16'h0008, "R2");
        reg_read(2'd0, 16'h0000, "R2");

        // R3 masked event, two-edge latency; R4 mask clear releases
        reg_write(2'd1, 16'h0010);
        pulse(4);
        check_irq(1'b1, "R3");
        tick();
        check_irq(1'b0, "R3");
        reg_write(2'd1, 16'h0000);
        check_irq(1'b0, "R4");
        tick();
        check_irq(1'b1, "R4");
        reg_read(2'd0, 16'h0010, "R2");

        // R4 release by clearing read
        reg_write(2'd1, 16'h0004);
        pulse(2);
        tick();
        check_irq(1'b0, "R3");
        reg_read(2'd0, 16'h0004, "R2");
        check_irq(1'b0, "R4");
        tick();
        check_irq(1'b1, "R4");
        reg_write(2'd1, 16'h0000);

        // R7 writable mask bits, ignored writes
        reg_write(2'd1, 16'hFFFF);
        reg_read(2'd1, 16'h00FE, "R7");
        reg_write(2'd0, 16'hFFFF);
        reg_read(2'd0, 16'h0000, "R7");
        reg_write(2'd3, 16'hFFFF);
        reg_read(2'd3, 16'h0000, "R7");
        tick();
        check_irq(1'b1, "R7");

        // R5 energy timeout exact edge
        reg_write(2'd1, 16'h0080);
        energy = 1'b0;
        ticks(NOE - 1);
        reg_read(2'd2, 16'h0002, "R5");
        reg_read(2'd2, 16'h0000, "R5");
        reg_read(2'd0, 16'h0000, "R5");
        energy = 1'b1;
        tick();
        check_irq(1'b1, "R5");
        tick();
        check_irq(1'b0, "R5");

        // R6 condition removed, then write 1 to mask bit 7
        energy = 1'b0;
        ticks(NOE);
        reg_read(2'd2, 16'h0000, "R5");
        check_irq(1'b0, "R6");
        reg_write(2'd1, 16'h0080);
        tick();
        check_irq(1'b1, "R6");
        reg_read(2'd0, 16'h0000, "R6");
        reg_read(2'd1, 16'h0080, "R6");

        // R6 no clear while energy present
        energy = 1'b1;
        tick();
        reg_write(2'd1, 16'h0080);
        reg_read(2'd0, 16'h0080, "R6");

        // R8 alternate mode bit
        reg_write(2'd2, 16'hFFFD);
        reg_read(2'd2, 16'h0003, "R8");
        energy = 1'b0;
        ticks(NOE);
        reg_read(2'd2, 16'h0001, "R8");

        // R9 software reset keeps energy status
        reg_write(2'd1, 16'h0002);
        pulse(1);
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
        tick();
        check_irq(1'b1, "R9");
        reg_read(2'd0, 16'h0000, "R9");
        reg_read(2'd1, 16'h0000, "R9");
        reg_read(2'd2, 16'h0000, "R9");
        energy = 1'b1;
        tick();
        reg_read(2'd2, 16'h0002, "R9");
        reg_read(2'd0, 16'h0080, "R5");

        ticks(2);
        finish_run();
    end

endmodule